// File: doc/BRIEF.md
# UART Interrupt Priority Controller

This block gathers every interrupt condition of a 16550-style UART with extended flow control. It turns them into one six-bit interrupt status code and one active-high interrupt line. The event inputs are single-cycle pulses from the line-status, modem-status and character-match logic. The FIFO levels and thresholds are live values from the receive and transmit queues. The read and write strobes come from the register decoder, and each source is cleared by its own register access.

The block owns the receive time-out timer. The timer advances on a bit-rate tick while receive data waits in the FIFO. It starts over whenever a character arrives or the receive holding register is read. It fires after four character times plus twelve bit times, and the character length in bits is a configuration input. A per-source enable vector masks sources out of both the code and the interrupt line. A masked source stays latched, so it appears as soon as it is enabled again.

Top module: `uart_irq_prio`

## Requirements
- R1: With no enabled source pending, `isr_code` is 6'b000001 and `irq` is 0. Whenever an enabled source is pending, `irq` is 1 and `isr_code[0]` is 0.
- R2: A pulse on any bit of `lsr_evt` latches the line-status source, reported as 6'b000110. Only `lsr_rd` clears it. An event arriving in the same cycle as the read keeps it set.
- R3: The data-ready source, code 6'b000100, is active exactly while `rx_level >= rx_trig`. It drops as soon as the level falls below the trigger.
- R4: While `rx_level` is non-zero, the time-out source (code 6'b001100) sets on the `4*bits_per_char+12`-th `bit_tick` counted after the last `rx_char` or `rhr_rd`. `rhr_rd` clears it, and no time-out forms while the FIFO is empty.
- R5: The transmit source, code 6'b000010, sets when `tx_level` newly reaches `tx_level <= tx_trig` and again when it newly becomes 0. Either `isr_rd` or `thr_wr` clears it.
- R6: A pulse on any bit of `msr_evt` latches the modem-status source, code 6'b000000 with `irq` 1. Only `msr_rd` clears it.
- R7: A pulse on any bit of `xchar_evt` (Xoff, Xon, special character) latches code 6'b010000. `isr_rd` clears it and `msr_rd` does not.
- R8: A low-to-high change of `cts_in` latches the flow-change source (code 6'b100000) only when `auto_cts_en` and `flow_sel` are both 1. The same holds for `rts_in` with `auto_rts_en` and `flow_sel`. `msr_rd` clears it.
- R9: A `wake_evt` pulse latches the wake source, also code 6'b100000 and ranked below the flow-change source. Only `int0_rd` clears it.
- R10: When several sources are active, the code follows this ranking: line status, data ready, time-out, transmit, modem status, character match, flow change, wake.
- R11: `irq_en` bit 0 gates line status, bit 1 gates both data ready and time-out, and bit 2 gates transmit. Bit 3 gates modem status, bit 4 character match, bit 5 flow change and bit 6 wake. A disabled source keeps its latched state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger threshold |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_trig | input | LVL_W | Transmit trigger threshold |
| bit_tick | input | 1 | One pulse per bit time |
| rx_char | input | 1 | A character entered the receive FIFO |
| bits_per_char | input | BPC_W | Bits per character, framing included |
| lsr_evt | input | 4 | Line error event pulses |
| msr_evt | input | 4 | Modem status change pulses |
| xchar_evt | input | 3 | Xoff, Xon, special character match pulses |
| cts_in | input | 1 | CTS pin level |
| rts_in | input | 1 | RTS pin level |
| auto_cts_en | input | 1 | Automatic CTS flow control on |
| auto_rts_en | input | 1 | Automatic RTS flow control on |
| flow_sel | input | 1 | Flow-change interrupt selection |
| wake_evt | input | 1 | Leaving sleep mode |
| irq_en | input | 7 | Per-source enables |
| lsr_rd | input | 1 | Line status register read |
| rhr_rd | input | 1 | Receive holding register read |
| isr_rd | input | 1 | Interrupt status register read |
| thr_wr | input | 1 | Transmit holding register write |
| msr_rd | input | 1 | Modem status register read |
| int0_rd | input | 1 | Wake status register read |
| isr_code | output | 6 | Encoded interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default widths: 7-bit FIFO levels, which covers a 64-entry FIFO, and 4-bit character length. It holds `bit_tick` high, so one bit time lasts one clock. With 5 and 8 bits per character, the time-out limit is 32 and 44 cycles. That short window allows the exact firing cycle to be checked on both sides. It also allows the time-out to be held long enough to confirm it stays masked under data ready.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam logic [5:0] CODE_LSR  = 6'b000110;
  localparam logic [5:0] CODE_RDY  = 6'b000100;
  localparam logic [5:0] CODE_TMO  = 6'b001100;
  localparam logic [5:0] CODE_THR  = 6'b000010;
  localparam logic [5:0] CODE_MSR  = 6'b000000;
  localparam logic [5:0] CODE_XCH  = 6'b010000;
  localparam logic [5:0] CODE_FLOW = 6'b100000;
  localparam logic [5:0] CODE_NONE = 6'b000001;

  // active-vector positions, highest rank first
  localparam int A_LSR = 0, A_RDY = 1, A_TMO = 2, A_THR = 3,
                 A_MSR = 4, A_XCH = 5, A_FLOW = 6, A_WAKE = 7;
  localparam int N_ACT = 8;

  // latched sources
  localparam int S_LSR = 0, S_THR = 1, S_MSR = 2, S_XCH = 3,
                 S_FLOW = 4, S_WAKE = 5;
  localparam int N_STICKY = 6;

  // time-out: four character times plus twelve bit times
  function automatic int unsigned tmo_limit(input int unsigned bpc);
    return 4 * bpc + 12;
  endfunction

  function automatic logic [5:0] pick_code(input logic [N_ACT-1:0] act);
    if (act[A_LSR])                    return CODE_LSR;
    else if (act[A_RDY])               return CODE_RDY;
    else if (act[A_TMO])               return CODE_TMO;
    else if (act[A_THR])               return CODE_THR;
    else if (act[A_MSR])               return CODE_MSR;
    else if (act[A_XCH])               return CODE_XCH;
    else if (act[A_FLOW] || act[A_WAKE]) return CODE_FLOW;
    else                               return CODE_NONE;
  endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  // a new event wins over a clearing access in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= set | (pend & ~clr);
  end
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
  import uart_irq_pkg::*;
#(
  parameter int BPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             active,
  input  logic [BPC_W-1:0] bpc,
  input  logic             clr,
  output logic             fire,
  output logic             pend
);
  localparam int MAX_LIM = 4 * ((1 << BPC_W) - 1) + 12;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(tmo_limit(int'(bpc)));
  assign fire  = active & tick & ~restart & (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (restart || !active)         cnt <= '0;
    else if (tick && cnt < limit)        cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (clr)  pend <= 1'b0;
    else if (fire) pend <= 1'b1;
  end
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
(
  input  logic [N_ACT-1:0] act,
  output logic [5:0]       code,
  output logic             irq
);
  assign code = pick_code(act);
  assign irq  = |act;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 7,
  parameter int BPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic             bit_tick,
  input  logic             rx_char,
  input  logic [BPC_W-1:0] bits_per_char,
  input  logic [3:0]       lsr_evt,
  input  logic [3:0]       msr_evt,
  input  logic [2:0]       xchar_evt,
  input  logic             cts_in,
  input  logic             rts_in,
  input  logic             auto_cts_en,
  input  logic             auto_rts_en,
  input  logic             flow_sel,
  input  logic             wake_evt,
  input  logic [6:0]       irq_en,
  input  logic             lsr_rd,
  input  logic             rhr_rd,
  input  logic             isr_rd,
  input  logic             thr_wr,
  input  logic             msr_rd,
  input  logic             int0_rd,
  output logic [5:0]       isr_code,
  output logic             irq
);
  // named internal events (observed by the bound checker)
  logic                rx_rdy;
  logic                tmo_fire;
  logic                tmo_pend;
  logic                thr_set;
  logic                flow_set;
  logic [N_STICKY-1:0] set_v, clr_v, pend;
  logic [N_ACT-1:0]    act;

  // transmit: edges of "at/below trigger" and "empty"
  logic tx_at_trig, tx_empty, tx_at_trig_q, tx_empty_q;
  logic cts_q, rts_q;

  assign tx_at_trig = (tx_level <= tx_trig);
  assign tx_empty   = (tx_level == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_at_trig_q <= 1'b1;
      tx_empty_q   <= 1'b1;
      cts_q        <= 1'b1;
      rts_q        <= 1'b1;
    end else begin
      tx_at_trig_q <= tx_at_trig;
      tx_empty_q   <= tx_empty;
      cts_q        <= cts_in;
      rts_q        <= rts_in;
    end
  end

  assign thr_set  = (tx_at_trig & ~tx_at_trig_q) | (tx_empty & ~tx_empty_q);
  assign flow_set = flow_sel & ((auto_cts_en & cts_in & ~cts_q) |
                                (auto_rts_en & rts_in & ~rts_q));
  assign rx_rdy   = (rx_level >= rx_trig);

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[S_LSR]  = |lsr_evt;   clr_v[S_LSR]  = lsr_rd;
    set_v[S_THR]  = thr_set;    clr_v[S_THR]  = isr_rd | thr_wr;
    set_v[S_MSR]  = |msr_evt;   clr_v[S_MSR]  = msr_rd;
    set_v[S_XCH]  = |xchar_evt; clr_v[S_XCH]  = isr_rd;
    set_v[S_FLOW] = flow_set;   clr_v[S_FLOW] = msr_rd;
    set_v[S_WAKE] = wake_evt;   clr_v[S_WAKE] = int0_rd;
  end

  for (genvar i = 0; i < N_STICKY; i++) begin : g_src
    uart_irq_sticky u_src (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set_v[i]),
      .clr  (clr_v[i]),
      .pend (pend[i])
    );
  end

  uart_irq_timeout #(.BPC_W(BPC_W)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (bit_tick),
    .restart(rx_char | rhr_rd),
    .active (rx_level != '0),
    .bpc    (bits_per_char),
    .clr    (rhr_rd),
    .fire   (tmo_fire),
    .pend   (tmo_pend)
  );

  always_comb begin
    act         = '0;
    act[A_LSR]  = pend[S_LSR]  & irq_en[0];
    act[A_RDY]  = rx_rdy       & irq_en[1];
    act[A_TMO]  = tmo_pend     & irq_en[1];
    act[A_THR]  = pend[S_THR]  & irq_en[2];
    act[A_MSR]  = pend[S_MSR]  & irq_en[3];
    act[A_XCH]  = pend[S_XCH]  & irq_en[4];
    act[A_FLOW] = pend[S_FLOW] & irq_en[5];
    act[A_WAKE] = pend[S_WAKE] & irq_en[6];
  end

  uart_irq_encode u_enc (
    .act (act),
    .code(isr_code),
    .irq (irq)
  );
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       lsr_evt,
  input logic             wake_evt,
  input logic             lsr_rd,
  input logic             rhr_rd,
  input logic             isr_rd,
  input logic             thr_wr,
  input logic             int0_rd,
  input logic             flow_sel,
  input logic [LVL_W-1:0] rx_level,
  input logic [5:0]       isr_code,
  input logic             irq,
  input logic [5:0]       pend,
  input logic             tmo_pend,
  input logic             rx_rdy,
  input logic             thr_set
);
  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !isr_code[0]);

  // R2
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && lsr_evt == 4'b0) |=> !pend[0]);

  // R4
  tmo_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_pend) |-> $past(rx_level) != '0);

  // R4
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rhr_rd |=> !tmo_pend);

  // R5
  thr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_rd || thr_wr) && !thr_set) |=> !pend[1]);

  // R8
  flow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[4]) |-> $past(flow_sel));

  // R9
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int0_rd && !wake_evt) |=> !pend[5]);

  // R10
  tmo_below_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_code == 6'b001100) |-> !rx_rdy);
endmodule

bind uart_irq_prio uart_irq_prio_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/uart_irq_prio_tb.sv
module uart_irq_prio_tb;
  localparam int LVL_W = 7;
  localparam int BPC_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0] rx_level = '0, rx_trig = 7'd8, tx_level = 7'd10, tx_trig = 7'd4;
  logic bit_tick = 1'b1, rx_char = 1'b0;
  logic [BPC_W-1:0] bits_per_char = 4'd5;
  logic [3:0] lsr_evt = '0, msr_evt = '0;
  logic [2:0] xchar_evt = '0;
  logic cts_in = 1'b0, rts_in = 1'b0, auto_cts_en = 1'b0, auto_rts_en = 1'b0, flow_sel = 1'b0;
  logic wake_evt = 1'b0;
  logic [6:0] irq_en = 7'h7f;
  logic lsr_rd = 0, rhr_rd = 0, isr_rd = 0, thr_wr = 0, msr_rd = 0, int0_rd = 0;
  logic [5:0] isr_code;
  logic irq;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_prio #(.LVL_W(LVL_W), .BPC_W(BPC_W)) u_dut (.*);

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] exp_code, input logic exp_irq);
    checks++;
    if (isr_code !== exp_code || irq !== exp_irq) begin
      errs++;
      $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
               req, isr_code, irq, exp_code, exp_irq);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset", 6'b000001, 1'b0);
  endtask

  task automatic t_lsr;
    lsr_evt = 4'b0100; step(); lsr_evt = '0; step();
    chk("R2 set", 6'b000110, 1'b1);
    lsr_rd = 1; lsr_evt = 4'b0001; step(); lsr_rd = 0; lsr_evt = '0;
    chk("R2 event with read", 6'b000110, 1'b1);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R2 clear", 6'b000001, 1'b0);
  endtask

  task automatic t_rxrdy;
    rx_level = 7'd7; step();
    chk("R3 below trigger", 6'b000001, 1'b0);
    rx_level = 7'd8; step();
    chk("R3 at trigger", 6'b000100, 1'b1);
    rx_level = 7'd7; step();
    chk("R3 drop", 6'b000001, 1'b0);
    rx_level = '0; step();
  endtask

  task automatic t_timeout(input int bpc);
    int lim;
    lim = 4 * bpc + 12;
    bits_per_char = BPC_W'(bpc);
    rx_level = 7'd2; rx_char = 1; step(); rx_char = 0;
    step(lim - 1);
    chk("R4 one tick early", 6'b000001, 1'b0);
    step();
    chk("R4 fires", 6'b001100, 1'b1);
    rhr_rd = 1; step(); rhr_rd = 0;
    chk("R4 cleared by rhr read", 6'b000001, 1'b0);
    rx_level = '0; step();
  endtask

  task automatic t_tmo_empty;
    rx_level = '0; step(100);
    chk("R4 empty fifo", 6'b000001, 1'b0);
  endtask

  task automatic t_level2;
    bits_per_char = 4'd5;
    rx_level = 7'd8; rx_char = 1; step(); rx_char = 0;
    step(40);
    chk("R10 ready over time-out", 6'b000100, 1'b1);
    rx_level = 7'd7; step();
    chk("R10 time-out visible", 6'b001100, 1'b1);
    rhr_rd = 1; step(); rhr_rd = 0;
    rx_level = '0; step();
    chk("R4 clear after level 2", 6'b000001, 1'b0);
  endtask

  task automatic t_thr;
    tx_level = 7'd4; step(2);
    chk("R5 reach trigger", 6'b000010, 1'b1);
    isr_rd = 1; step(); isr_rd = 0;
    chk("R5 isr read clears", 6'b000001, 1'b0);
    tx_level = '0; step();
    chk("R5 empty", 6'b000010, 1'b1);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R5 write clears", 6'b000001, 1'b0);
    tx_level = 7'd10; step();
  endtask

  task automatic t_msr;
    msr_evt = 4'b0001; step(); msr_evt = '0;
    chk("R6 set", 6'b000000, 1'b1);
    isr_rd = 1; step(); isr_rd = 0;
    chk("R6 isr read ignored", 6'b000000, 1'b1);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R6 clear", 6'b000001, 1'b0);
  endtask

  task automatic t_xchar;
    xchar_evt = 3'b010; step(); xchar_evt = '0;
    chk("R7 set", 6'b010000, 1'b1);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R7 msr read ignored", 6'b010000, 1'b1);
    isr_rd = 1; step(); isr_rd = 0;
    chk("R7 clear", 6'b000001, 1'b0);
  endtask

  task automatic t_flow;
    auto_cts_en = 1; flow_sel = 0;
    cts_in = 1; step(); cts_in = 0; step();
    chk("R8 cts without selection", 6'b000001, 1'b0);
    flow_sel = 1; auto_cts_en = 0;
    cts_in = 1; step(); cts_in = 0; step();
    chk("R8 cts not enabled", 6'b000001, 1'b0);
    auto_cts_en = 1;
    cts_in = 1; step(); cts_in = 0;
    chk("R8 cts rise", 6'b100000, 1'b1);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R8 clear", 6'b000001, 1'b0);
    auto_rts_en = 1;
    rts_in = 1; step(); rts_in = 0;
    chk("R8 rts rise", 6'b100000, 1'b1);
    msr_rd = 1; step(); msr_rd = 0;
    auto_cts_en = 0; auto_rts_en = 0; flow_sel = 0; step();
  endtask

  task automatic t_wake;
    wake_evt = 1; step(); wake_evt = 0;
    chk("R9 set", 6'b100000, 1'b1);
    isr_rd = 1; msr_rd = 1; step(); isr_rd = 0; msr_rd = 0;
    chk("R9 other reads ignored", 6'b100000, 1'b1);
    int0_rd = 1; step(); int0_rd = 0;
    chk("R9 clear", 6'b000001, 1'b0);
  endtask

  task automatic t_prio;
    lsr_evt = 4'b1000; msr_evt = 4'b0010; xchar_evt = 3'b001; tx_level = 7'd3;
    step(); lsr_evt = '0; msr_evt = '0; xchar_evt = '0;
    chk("R10 line status first", 6'b000110, 1'b1);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R10 transmit next", 6'b000010, 1'b1);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R10 modem next", 6'b000000, 1'b1);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R10 char match last", 6'b010000, 1'b1);
    isr_rd = 1; step(); isr_rd = 0;
    tx_level = 7'd10; step();
  endtask

  task automatic t_mask;
    irq_en = 7'b1111110;
    lsr_evt = 4'b0010; step(); lsr_evt = '0;
    chk("R11 masked", 6'b000001, 1'b0);
    irq_en = 7'h7f; step();
    chk("R11 retained", 6'b000110, 1'b1);
    lsr_rd = 1; step(); lsr_rd = 0;
    irq_en = 7'b1111101; rx_level = 7'd9; step();
    chk("R11 data ready masked", 6'b000001, 1'b0);
    rx_level = '0; irq_en = 7'h7f; step();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_lsr();
    t_rxrdy();
    t_timeout(5);
    t_timeout(8);
    t_tmo_empty();
    t_level2();
    t_thr();
    t_msr();
    t_xchar();
    t_flow();
    t_wake();
    t_prio();
    t_mask();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule